// File: doc/BRIEF.md
# Segmented Host Port with Cascade Flags for an Associative Memory

This block sits between a 64-bit associative memory core and a narrow 16-bit shared bus. A host runs bus cycles with four strobes: an active-low enable that frames each cycle, a write/read select, a command/data select and a compare enable. All strobes are sampled by the system clock. The falling edge of the enable opens a cycle and captures the three control strobes. The rising edge closes the cycle, and on that edge the write payload is taken and the segment pointer moves.

A core word is carried as four 16-bit pieces in turn. Each data cycle moves one piece. The fourth written piece sends the assembled word to the core in a single-cycle pulse. Command cycles are kept apart from data cycles. A written command goes to the core as a one-cycle pulse with its bus value. A read command returns a status word.

The block also forms the two cascade flags, both active low. The match flag passes a match from a higher-priority device down the chain. A local match is added only when compare enable was captured active for the current cycle. The full flag reports the whole chain as full only when this device and every device above it are full. The top device ties its match input high and its full input low.

Top module: `cam_host_port`

## Requirements
- R1: After reset the segment pointer is 0, both cascade outputs are high, the bus driver is off, and no word or command pulse is issued.
- R2: Write select, command select and compare enable are captured in the clock after the enable is first seen low. Changes to them while the enable stays low have no effect on that cycle.
- R3: Each data cycle, read or write, moves the segment pointer one step when the enable is first seen high again. The step is 0→1→2→3→0.
- R4: A command cycle, read or write, sets the segment pointer to 0 at its close. A write command (write select low) issues `cmd_wr` for one clock with `cmd_data` equal to the bus value present at the close.
- R5: When a write data cycle closes with the pointer at 3, `word_wr` pulses for one clock. `word_data[16*i+15:16*i]` then holds the piece written at pointer i.
- R6: `dq_oe` is high exactly from the clock after the enable falls until the clock the enable is seen high, and only when write select was captured high. In a read data cycle `dq_out` equals bits `[16*p+15:16*p]` of `core_rd_word`, where p is the segment pointer.
- R7: In a read command cycle `dq_out` carries bit 2 = `core_full` and bits 1:0 = segment pointer, with all other bits 0.
- R8: `match_out_n` is low when `match_in_n` is low. It is also low when compare enable was captured low for the current cycle and `core_match` is high. In every other case it is high.
- R9: `full_out_n` is low only when `core_full` is high and `full_in_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_n | input | 1 | Cycle enable strobe, active low |
| wr_n | input | 1 | Low: write cycle, high: read cycle |
| cmd_n | input | 1 | Low: command cycle, high: data cycle |
| cmp_n | input | 1 | Compare enable, active low |
| dq_in | input | 16 | Bus value driven by host |
| dq_out | output | 16 | Bus value driven by block |
| dq_oe | output | 1 | Bus driver enable |
| match_in_n | input | 1 | Match from higher-priority device, active low |
| full_in_n | input | 1 | Full from higher-priority device, active low |
| match_out_n | output | 1 | Cascaded match flag, active low |
| full_out_n | output | 1 | Cascaded full flag, active low |
| core_match | input | 1 | Local valid match from core |
| core_full | input | 1 | Local array has every location valid |
| core_rd_word | input | 64 | Word presented by core for reads |
| word_wr | output | 1 | One-clock commit of assembled word |
| word_data | output | 64 | Assembled word |
| cmd_wr | output | 1 | One-clock command strobe |
| cmd_data | output | 16 | Command value |

## Verification
The enable edges become visible one clock after the enable changes. The latched controls, `dq_oe` and the gating of the match flag therefore change in the clock after the fall. The pointer, `word_wr` and `cmd_wr` change in the clock after the rise. `dq_out` and both cascade flags follow their inputs within the same clock once the latched state is set. The bench drives inputs on the falling clock edge. It updates its reference at the rising edge and compares a quarter period later, so each result is checked in the clock it is due and pulses are checked for their one-clock width.

// File: rtl/cam_host_port.sv
module cam_host_port #(
  parameter int SEG_W = 16,
  parameter int SEGS  = 4,
  localparam int WORD_W = SEG_W * SEGS,
  localparam int CNT_W  = (SEGS > 1) ? $clog2(SEGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              wr_n,
  input  logic              cmd_n,
  input  logic              cmp_n,
  input  logic [SEG_W-1:0]  dq_in,
  output logic [SEG_W-1:0]  dq_out,
  output logic              dq_oe,
  input  logic              match_in_n,
  input  logic              full_in_n,
  output logic              match_out_n,
  output logic              full_out_n,
  input  logic              core_match,
  input  logic              core_full,
  input  logic [WORD_W-1:0] core_rd_word,
  output logic              word_wr,
  output logic [WORD_W-1:0] word_data,
  output logic              cmd_wr,
  output logic [SEG_W-1:0]  cmd_data
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(SEGS - 1);

  logic              en_q, active;
  logic              lat_rd, lat_data, lat_cmp;
  logic [CNT_W-1:0]  seg_q;
  logic [WORD_W-1:0] buf_q, buf_nxt;

  wire fall = en_q & ~en_n;
  wire rise = ~en_q & en_n & active;

  always_comb begin
    buf_nxt = buf_q;
    buf_nxt[int'(seg_q)*SEG_W +: SEG_W] = dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b1;
      active    <= 1'b0;
      lat_rd    <= 1'b0;
      lat_data  <= 1'b1;
      lat_cmp   <= 1'b0;
      seg_q     <= '0;
      buf_q     <= '0;
      word_wr   <= 1'b0;
      word_data <= '0;
      cmd_wr    <= 1'b0;
      cmd_data  <= '0;
    end else begin
      en_q    <= en_n;
      word_wr <= 1'b0;
      cmd_wr  <= 1'b0;
      if (fall) begin
        active   <= 1'b1;
        lat_rd   <= wr_n;
        lat_data <= cmd_n;
        lat_cmp  <= ~cmp_n;
      end
      if (rise) begin
        active <= 1'b0;
        if (!lat_data) begin
          seg_q <= '0;
          if (!lat_rd) begin
            cmd_wr   <= 1'b1;
            cmd_data <= dq_in;
          end
        end else begin
          seg_q <= (seg_q == LAST) ? '0 : seg_q + 1'b1;
          if (!lat_rd) begin
            buf_q <= buf_nxt;
            if (seg_q == LAST) begin
              word_wr   <= 1'b1;
              word_data <= buf_nxt;
            end
          end
        end
      end
    end
  end

  assign dq_oe = active & lat_rd;
  assign dq_out = lat_data ? core_rd_word[int'(seg_q)*SEG_W +: SEG_W]
                           : {{(SEG_W-1-CNT_W){1'b0}}, core_full, seg_q};
  assign match_out_n = match_in_n & ~(lat_cmp & core_match);
  assign full_out_n  = ~(core_full & ~full_in_n);

endmodule

module cam_host_port_chk #(
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_n,
  input logic             match_in_n,
  input logic             match_out_n,
  input logic             full_in_n,
  input logic             full_out_n,
  input logic             dq_oe,
  input logic             word_wr,
  input logic             cmd_wr,
  input logic [CNT_W-1:0] seg
);

  p_reset_quiet_r1: assert property (@(posedge clk) $rose(rst_n) |-> seg == '0 && !word_wr && !cmd_wr);

  p_oe_inside_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !$past(en_n));

  p_seg_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seg != $past(seg) |-> (seg == $past(seg) + 1'b1) || (seg == '0));

  p_cmd_clears_seg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> seg == '0);

  p_commit_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_wr |=> !word_wr);

  p_commit_on_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_wr |-> $past(en_n) && !$past(en_n, 2));

  p_match_passes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !match_in_n |-> !match_out_n);

  p_full_needs_upstream_r9: assert property (@(posedge clk) disable iff (!rst_n)
    full_in_n |-> full_out_n);

endmodule

bind cam_host_port cam_host_port_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en_n(en_n),
  .match_in_n(match_in_n), .match_out_n(match_out_n),
  .full_in_n(full_in_n), .full_out_n(full_out_n),
  .dq_oe(dq_oe), .word_wr(word_wr), .cmd_wr(cmd_wr), .seg(seg_q)
);

// File: tb/cam_host_port_tb.sv
module cam_host_port_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_n = 1'b1, wr_n = 1'b1, cmd_n = 1'b1, cmp_n = 1'b1;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic        dq_oe;
  logic        match_in_n = 1'b1, full_in_n = 1'b0;
  logic        match_out_n, full_out_n;
  logic        core_match = 1'b0, core_full = 1'b0;
  logic [63:0] core_rd_word = 64'h1111_2222_3333_4444;
  logic        word_wr, cmd_wr;
  logic [63:0] word_data;
  logic [15:0] cmd_data;

  int checks = 0, fails = 0;
  bit done = 0;

  cam_host_port dut_i (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .wr_n(wr_n), .cmd_n(cmd_n), .cmp_n(cmp_n),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .match_in_n(match_in_n), .full_in_n(full_in_n),
    .match_out_n(match_out_n), .full_out_n(full_out_n),
    .core_match(core_match), .core_full(core_full), .core_rd_word(core_rd_word),
    .word_wr(word_wr), .word_data(word_data), .cmd_wr(cmd_wr), .cmd_data(cmd_data)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference
  bit          m_enq = 1, m_act = 0, m_rd = 0, m_data = 1, m_cmp = 0;
  int          m_seg = 0;
  logic [15:0] m_piece [4];
  bit          m_wv = 0, m_cv = 0;
  logic [63:0] m_word = '0;
  logic [15:0] m_cmd = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_enq = 1; m_act = 0; m_rd = 0; m_data = 1; m_cmp = 0; m_seg = 0;
      m_wv = 0; m_cv = 0; m_word = '0; m_cmd = '0;
      foreach (m_piece[i]) m_piece[i] = '0;
    end else begin
      m_wv = 0; m_cv = 0;
      if (m_enq && !en_n) begin
        m_act = 1; m_rd = wr_n; m_data = cmd_n; m_cmp = !cmp_n;
      end else if (!m_enq && en_n && m_act) begin
        m_act = 0;
        if (!m_data) begin
          m_seg = 0;
          if (!m_rd) begin m_cv = 1; m_cmd = dq_in; end
        end else begin
          if (!m_rd) begin
            m_piece[m_seg] = dq_in;
            if (m_seg == 3) begin
              m_wv = 1;
              m_word = {m_piece[3], m_piece[2], m_piece[1], m_piece[0]};
            end
          end
          m_seg = (m_seg + 1) % 4;
        end
      end
      m_enq = en_n;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_P/4);
    if (!done) begin
      logic [15:0] exp_dq;
      exp_dq = m_data ? core_rd_word[m_seg*16 +: 16] : {13'b0, core_full, 2'(m_seg)};
      if (!rst_n) begin
        chk("R1", "dq_oe", 64'(dq_oe), 64'(0));
        chk("R1", "word_wr", 64'(word_wr), 64'(0));
        chk("R1", "cmd_wr", 64'(cmd_wr), 64'(0));
        chk("R1", "match_out_n", 64'(match_out_n), 64'(1));
      end else begin
        chk("R2/R6", "dq_oe", 64'(dq_oe), 64'(m_act && m_rd));
        if (m_act && m_rd)
          chk(m_data ? "R3/R6" : "R4/R7", "dq_out", 64'(dq_out), 64'(exp_dq));
        chk("R5", "word_wr", 64'(word_wr), 64'(m_wv));
        if (m_wv) chk("R5", "word_data", word_data, m_word);
        chk("R4", "cmd_wr", 64'(cmd_wr), 64'(m_cv));
        if (m_cv) chk("R4", "cmd_data", 64'(cmd_data), 64'(m_cmd));
        chk("R8", "match_out_n", 64'(match_out_n),
            64'(!(!match_in_n || (m_cmp && core_match))));
        chk("R9", "full_out_n", 64'(full_out_n), 64'(!(core_full && !full_in_n)));
      end
    end
  end

  task automatic cyc(input logic w, input logic c, input logic k, input logic [15:0] d,
                     input bit perturb);
    @(negedge clk);
    wr_n = w; cmd_n = c; cmp_n = k; dq_in = d; en_n = 1'b0;
    @(negedge clk);
    if (perturb) begin wr_n = ~w; cmd_n = ~c; cmp_n = ~k; end
    @(negedge clk);
    en_n = 1'b1;
    @(negedge clk);
    wr_n = 1'b1; cmd_n = 1'b1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 50000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 idle after reset, R9 local empty
    repeat (2) @(negedge clk);
    // R5 R3: four written data pieces with compare enabled (R8)
    core_match = 1'b1;
    cyc(1'b0, 1'b1, 1'b0, 16'hA0A0, 1'b0);
    cyc(1'b0, 1'b1, 1'b0, 16'hB1B1, 1'b1);  // R2 perturb
    cyc(1'b0, 1'b1, 1'b1, 16'hC2C2, 1'b0);  // R8 compare disabled
    cyc(1'b0, 1'b1, 1'b0, 16'hD3D3, 1'b0);
    // R6: read all pieces, with perturbation on one (R2)
    core_rd_word = 64'hFEDC_BA98_7654_3210;
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b1, 16'h0, i == 2);
    // R4: partial data then command write resets pointer
    cyc(1'b0, 1'b1, 1'b1, 16'h1234, 1'b0);
    cyc(1'b0, 1'b1, 1'b1, 16'h5678, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 16'h9ABC, 1'b0);
    // R7: status read, full and not full
    core_full = 1'b1;
    cyc(1'b1, 1'b1, 1'b1, 16'h0, 1'b0);
    cyc(1'b1, 1'b0, 1'b1, 16'h0, 1'b0);
    core_full = 1'b0;
    cyc(1'b1, 1'b0, 1'b0, 16'h0, 1'b0);
    // R9 cascade full combos
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); core_full = i[0]; full_in_n = i[1];
    end
    // R8 cascade match combos
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); match_in_n = i[0]; core_match = i[1];
      if (i == 4) cyc(1'b1, 1'b1, 1'b0, 16'h0, 1'b0);
    end
    match_in_n = 1'b1;
    // R5 second word after wrap from a non-zero start
    cyc(1'b0, 1'b1, 1'b1, 16'h0001, 1'b0);
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b1, 16'(16'h1000 + i), 1'b0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule